// File: doc/BRIEF.md
# SPI Byte Port with Completion and Collision Flags

This block is a one-byte serial peripheral port for a small processor's I/O register bus. Software writes a byte to the data register to start an exchange. The exchange shifts eight bits, most significant bit first, either as clock master or as clock slave. When it ends, the received byte is copied into a receive buffer and the completion flag is set. The completion flag can raise an interrupt request.

The status register has four parts: the completion flag, a collision flag, a double-speed control bit and reserved bits. The collision flag sets when software writes the data register while a byte is still moving. A low level on the select input while the port is master is treated as a mode fault, which also sets the completion flag. Both flags clear after software reads the status register while a flag is set and then accesses the data register. The interrupt acknowledge input clears the completion flag alone.

Clock polarity is fixed: the serial clock idles low, input is sampled on its rising edge and output changes on its falling edge. The enable, master select, rate select and interrupt enables are plain input ports.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the status register reads 0x00, the data register reads 0x00, `irq` is 0 and `sckOut` is 0.
- R2: The status register is at bus address 0x2E and the data register at 0x2F. Status bit 7 is the completion flag, bit 6 is the collision flag, bits 5..1 always read 0, and bit 0 is a read/write double-speed bit.
- R3: In master mode an exchange takes DATA_W × D clock cycles from the data write to the completion flag. D is 4, 16, 64 or 128 for `rateSel` 0..3, and D is halved when the double-speed bit is 1.
- R4: In master mode the byte written goes out on `sdo` MSB first, and the byte sampled on `sdi` is placed in the data register when the exchange ends.
- R5: In slave mode with `ssN` low, eight bits are shifted on edges of `sckIn`. `sdo` carries the written byte MSB first, and the byte received on `sdi` is placed in the data register. With `ssN` high, `sckIn` edges have no effect.
- R6: A data-register write during an exchange sets the collision flag. The written byte is discarded and the byte in flight is not changed.
- R7: Both flags clear when the status register is read while either flag is set and the data register is then read or written. A data access with no such status read beforehand leaves the flags set.
- R8: `irq` is high exactly when the completion flag, `irqEnable` and `globalIrqEn` are all 1.
- R9: A one-cycle `irqAck` pulse clears the completion flag and leaves the collision flag unchanged.
- R10: With `spiOn` and `isMaster` high, a low `ssN` sets the completion flag and aborts any master exchange, returning `sckOut` low.
- R11: While an exchange is running, the data register returns the byte from the last completed exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 6 | Register bus address |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data (combinational) |
| spiOn | input | 1 | Port enable |
| isMaster | input | 1 | 1 = clock master, 0 = slave |
| rateSel | input | 2 | Master clock divisor select |
| irqEnable | input | 1 | Port interrupt enable |
| globalIrqEn | input | 1 | Global interrupt enable |
| irqAck | input | 1 | Interrupt acknowledge (vector taken) |
| irq | output | 1 | Interrupt request |
| sckOut | output | 1 | Serial clock out in master mode |
| sckIn | input | 1 | Serial clock in from an external master |
| ssN | input | 1 | Select input, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench measures the master exchange length for every divisor with and without double speed. A divider off by one half-period or a reversed speed bit gives a wrong cycle count. It checks the two-step flag clear in both orders and the acknowledge path. A design that clears on any data access, or whose acknowledge also clears the collision flag, leaves the wrong flags set. It also writes the data register in the middle of an exchange and checks that the byte on the wire is the original. A design that loads the late byte sends corrupted bits. Mode fault, slave exchanges and `sckIn` edges with `ssN` high are each exercised, because a design that ignores the select line sets the flag at the wrong time.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int HALF_W = 7;

  typedef struct packed {
    logic startTx;
    logic abortTx;
  } ctrlStrobe_t;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 6'h2E,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 6'h2F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              spiOn,
  input  logic              isMaster,
  input  logic              ssN,
  input  logic              irqEnable,
  input  logic              globalIrqEn,
  input  logic              irqAck,
  output logic              irq,
  output logic              dblSpeed,
  input  logic              xferDone,
  input  logic              xferBusy,
  input  logic [DATA_W-1:0] rxByte,
  output ctrlStrobe_t       strobe
);
  logic statusSel, dataSel, dataAccess, modeFault, collide, clearArm;
  logic spif, wcol, armed;

  assign statusSel  = (busAddr == STATUS_ADDR);
  assign dataSel    = (busAddr == DATA_ADDR);
  assign dataAccess = dataSel & (busRd | busWr);
  assign modeFault  = spiOn & isMaster & ~ssN;
  assign collide    = dataSel & busWr & xferBusy;
  assign clearArm   = dataAccess & armed;

  assign strobe.startTx = dataSel & busWr & ~xferBusy & spiOn & ~modeFault;
  assign strobe.abortTx = modeFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spif     <= 1'b0;
      wcol     <= 1'b0;
      armed    <= 1'b0;
      dblSpeed <= 1'b0;
    end else begin
      if (statusSel && busWr) dblSpeed <= busWdata[0];
      if (dataAccess) armed <= 1'b0;
      else if (statusSel && busRd && (spif || wcol)) armed <= 1'b1;
      if (clearArm || irqAck) spif <= 1'b0;
      if (xferDone || modeFault) spif <= 1'b1;
      if (clearArm) wcol <= 1'b0;
      if (collide) wcol <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (statusSel)    busRdata = {spif, wcol, {(DATA_W-3){1'b0}}, dblSpeed};
    else if (dataSel) busRdata = rxByte;
  end

  assign irq = spif & irqEnable & globalIrqEn;

  a_r10_fault_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> spif);
  a_r6_collision_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wcol) |-> $past(collide));
  a_r9_ack_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !xferDone && !modeFault) |=> !spif);
  a_r7_clear_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spif) |-> $past(irqAck || clearArm));
endmodule

// File: rtl/spi_port_datapath.sv
module spi_port_datapath
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] txByte,
  input  logic              spiOn,
  input  logic              isMaster,
  input  logic [1:0]        rateSel,
  input  logic              dblSpeed,
  input  logic              sckIn,
  input  logic              ssN,
  input  logic              sdi,
  output logic              sckOut,
  output logic              sdo,
  output logic              xferDone,
  output logic              xferBusy,
  output logic [DATA_W-1:0] rxByte
);
  logic [DATA_W-1:0] shiftReg, rxBuf, shiftNext;
  logic [CNT_W-1:0]  bitCnt;
  logic [HALF_W-1:0] divCnt, halfBase, halfLimit;
  logic [SYNC_STAGES-1:0] sckSync;
  logic busyM, slvActive, sckReg, rxBit, sckPrev, sckS;
  logic slvLive, slvRise, slvFall, mTick, mRise, mFall;
  logic sampleEdge, shiftEdge, lastBit;

  always_comb begin
    if (rateSel == 2'd3) halfBase = HALF_W'(64);
    else                 halfBase = HALF_W'(2) << (2 * rateSel);
    halfLimit = dblSpeed ? (halfBase >> 1) : halfBase;
  end

  assign sckS       = sckSync[SYNC_STAGES-1];
  assign slvLive    = spiOn & ~isMaster & ~ssN;
  assign slvRise    = slvLive & sckS & ~sckPrev;
  assign slvFall    = slvLive & ~sckS & sckPrev;
  assign mTick      = busyM & (divCnt == halfLimit - HALF_W'(1));
  assign mRise      = mTick & ~sckReg;
  assign mFall      = mTick & sckReg;
  assign sampleEdge = mRise | slvRise;
  assign shiftEdge  = mFall | slvFall;
  assign lastBit    = (bitCnt == CNT_W'(DATA_W-1));
  assign shiftNext  = {shiftReg[DATA_W-2:0], rxBit};
  assign xferDone   = shiftEdge & lastBit & ~strobe.abortTx;
  assign xferBusy   = busyM | slvActive;
  assign sckOut     = sckReg;
  assign sdo        = shiftReg[DATA_W-1];
  assign rxByte     = rxBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync   <= '0;
      sckPrev   <= 1'b0;
      shiftReg  <= '0;
      rxBuf     <= '0;
      rxBit     <= 1'b0;
      bitCnt    <= '0;
      divCnt    <= '0;
      busyM     <= 1'b0;
      slvActive <= 1'b0;
      sckReg    <= 1'b0;
    end else begin
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      sckPrev <= sckS;
      if (strobe.abortTx) begin
        busyM     <= 1'b0;
        slvActive <= 1'b0;
        sckReg    <= 1'b0;
        divCnt    <= '0;
        bitCnt    <= '0;
      end else begin
        if (!isMaster && !slvLive) begin
          slvActive <= 1'b0;
          bitCnt    <= '0;
        end
        if (strobe.startTx) begin
          shiftReg <= txByte;
          bitCnt   <= '0;
          if (isMaster) begin
            busyM  <= 1'b1;
            divCnt <= '0;
            sckReg <= 1'b0;
          end
        end
        if (busyM) begin
          if (mTick) begin
            divCnt <= '0;
            sckReg <= ~sckReg;
          end else begin
            divCnt <= divCnt + HALF_W'(1);
          end
        end
        if (sampleEdge) rxBit <= sdi;
        if (slvRise) slvActive <= 1'b1;
        if (shiftEdge) begin
          shiftReg <= shiftNext;
          bitCnt   <= bitCnt + CNT_W'(1);
          if (lastBit) begin
            rxBuf     <= shiftNext;
            busyM     <= 1'b0;
            slvActive <= 1'b0;
            bitCnt    <= '0;
          end
        end
      end
    end
  end

  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busyM |-> !sckReg);
  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !xferDone |=> $stable(rxBuf));
  a_r6_no_start_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |-> !strobe.startTx);
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_port_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 6'h2E,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 6'h2F,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              spiOn,
  input  logic              isMaster,
  input  logic [1:0]        rateSel,
  input  logic              irqEnable,
  input  logic              globalIrqEn,
  input  logic              irqAck,
  output logic              irq,
  output logic              sckOut,
  input  logic              sckIn,
  input  logic              ssN,
  input  logic              sdi,
  output logic              sdo
);
  ctrlStrobe_t       strobe;
  logic              dblSpeed, xferDone, xferBusy;
  logic [DATA_W-1:0] rxByte;

  spi_port_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .spiOn(spiOn), .isMaster(isMaster),
    .ssN(ssN), .irqEnable(irqEnable), .globalIrqEn(globalIrqEn), .irqAck(irqAck),
    .irq(irq), .dblSpeed(dblSpeed), .xferDone(xferDone), .xferBusy(xferBusy),
    .rxByte(rxByte), .strobe(strobe)
  );

  spi_port_datapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(busWdata), .spiOn(spiOn),
    .isMaster(isMaster), .rateSel(rateSel), .dblSpeed(dblSpeed), .sckIn(sckIn),
    .ssN(ssN), .sdi(sdi), .sckOut(sckOut), .sdo(sdo), .xferDone(xferDone),
    .xferBusy(xferBusy), .rxByte(rxByte)
  );
endmodule

// File: tb/sim_spi_byte_port.sv
`timescale 1ns/1ps
module sim_spi_byte_port;
  localparam logic [5:0] ST = 6'h2E;
  localparam logic [5:0] DT = 6'h2F;

  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic busRd = 0, busWr = 0;
  logic [7:0] busWdata = '0, busRdata;
  logic spiOn = 1, isMaster = 1, irqEnable = 1, globalIrqEn = 1, irqAck = 0;
  logic [1:0] rateSel = '0;
  logic irq, sckOut, sdo, sdi;
  logic sckIn = 0, ssN = 1, sSdi = 0, devArm = 0;
  logic [7:0] devOut = '0, capt = '0;
  int devIdx = 7;
  int vecs = 0, bad = 0;

  always #4 clk = ~clk;

  assign sdi = isMaster ? devOut[devIdx[2:0]] : sSdi;

  always @(negedge sckOut or posedge devArm)
    if (devArm) devIdx = 7;
    else if (devIdx > 0) devIdx = devIdx - 1;

  always @(posedge sckOut or posedge devArm)
    if (devArm) capt = '0;
    else capt = {capt[6:0], sdo};

  spi_byte_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .spiOn(spiOn), .isMaster(isMaster),
    .rateSel(rateSel), .irqEnable(irqEnable), .globalIrqEn(globalIrqEn),
    .irqAck(irqAck), .irq(irq), .sckOut(sckOut), .sckIn(sckIn), .ssN(ssN),
    .sdi(sdi), .sdo(sdo)
  );

  function automatic int expCycles(input logic [1:0] r, input logic d);
    int div = (r == 2'd3) ? 128 : (4 << (2 * r));
    return 8 * (d ? div / 2 : div);
  endfunction

  function automatic logic [7:0] expStatus(input logic f, input logic c, input logic d);
    return {f, c, 5'b0, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk); busWr = 0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1; #1 d = busRdata;
    @(negedge clk); busRd = 0;
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk); n++; #1;
      if (irq) break;
    end
  endtask

  task automatic masterXfer(input logic [1:0] r, input logic d, input logic [7:0] tx,
                            input logic [7:0] dev);
    int n;
    logic [7:0] v;
    rateSel = r;
    busWrite(ST, {7'b0, d});
    devOut = dev; devArm = 1; #1 devArm = 0;
    busWrite(DT, tx);
    waitIrq(n);
    chk("R3 cycles", n, expCycles(r, d));
    chk("R4 mosi bits", capt, tx);
    busRead(ST, v); chk("R2 status after done", v, expStatus(1, 0, d));
    busRead(DT, v); chk("R4 rx byte", v, dev);
    chk("R7 irq cleared", irq, 0);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1 chk("R1 irq", irq, 0); chk("R1 sckOut", sckOut, 0);
    busRead(ST, v); chk("R1 status", v, 8'h00);
    busRead(DT, v); chk("R1 data", v, 8'h00);
    // R2 reserved bits and speed bit
    busWrite(ST, 8'hFF); busRead(ST, v); chk("R2 reserved zero", v, 8'h01);
    busWrite(ST, 8'h00); busRead(ST, v); chk("R2 speed bit clear", v, 8'h00);
    // R3/R4 directed rate sweep
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 2; d++)
        masterXfer(2'(r), 1'(d), 8'h80 | 8'(r * 16 + d), 8'h01 ^ 8'(r));
    // random mix
    for (int i = 0; i < 10; i++)
      masterXfer(2'($urandom % 4), 1'($urandom % 2), 8'($urandom), 8'($urandom));
    // R6 collision + R11 rx hold
    masterXfer(2'd0, 1'b0, 8'h11, 8'h5A);
    rateSel = 0; busWrite(ST, 8'h00);
    devOut = 8'hA5; devArm = 1; #1 devArm = 0;
    busWrite(DT, 8'h3C);
    repeat (5) @(negedge clk);
    busRead(DT, v); chk("R11 rx holds last byte", v, 8'h5A);
    busWrite(DT, 8'hFF);
    waitIrq(n);
    busRead(ST, v); chk("R6 collision flag", v, 8'hC0);
    chk("R6 bits unchanged", capt, 8'h3C);
    busRead(DT, v); chk("R6 rx byte", v, 8'hA5);
    busRead(ST, v); chk("R7 both cleared", v, 8'h00);
    // R9 ack, R8 gating, R7 negative
    devArm = 1; #1 devArm = 0;
    busWrite(DT, 8'h77);
    repeat (3) @(negedge clk);
    busWrite(DT, 8'h00);
    waitIrq(n);
    irqEnable = 0; #1 chk("R8 local enable off", irq, 0);
    irqEnable = 1; globalIrqEn = 0; #1 chk("R8 global enable off", irq, 0);
    globalIrqEn = 1; #1 chk("R8 both enabled", irq, 1);
    busRead(DT, v); chk("R7 no arm keeps flag", irq, 1);
    @(negedge clk); irqAck = 1; @(negedge clk); irqAck = 0;
    chk("R9 ack clears irq", irq, 0);
    busRead(ST, v); chk("R9 collision kept", v, 8'h40);
    busRead(DT, v);
    busRead(ST, v); chk("R7 collision cleared", v, 8'h00);
    // R10 mode fault
    rateSel = 2'd1;
    devArm = 1; #1 devArm = 0;
    busWrite(DT, 8'h99);
    repeat (20) @(negedge clk);
    ssN = 0;
    repeat (2) @(negedge clk);
    chk("R10 fault sets flag", irq, 1);
    chk("R10 sck low after abort", sckOut, 0);
    ssN = 1;
    busRead(ST, v); chk("R10 status", v, 8'h80);
    busRead(DT, v); chk("R10 cleared", irq, 0);
    repeat (300) @(negedge clk);
    chk("R10 no late completion", irq, 0);
    // R5 slave
    isMaster = 0;
    for (int i = 0; i < 4; i++) begin
      sckIn = 1; repeat (6) @(negedge clk); sckIn = 0; repeat (6) @(negedge clk);
    end
    chk("R5 ignored with ssN high", irq, 0);
    ssN = 0; repeat (4) @(negedge clk);
    busWrite(DT, 8'hC3);
    capt = '0;
    for (int i = 7; i >= 0; i--) begin
      sSdi = 1'(8'h6E >> i);
      repeat (6) @(negedge clk);
      capt = {capt[6:0], sdo};
      sckIn = 1; repeat (6) @(negedge clk);
      sckIn = 0; repeat (6) @(negedge clk);
    end
    chk("R5 slave done", irq, 1);
    chk("R5 slave out bits", capt, 8'hC3);
    busRead(ST, v);
    busRead(DT, v); chk("R5 slave rx byte", v, 8'h6E);
    ssN = 1; isMaster = 1;
    masterXfer(2'd0, 1'b1, 8'hE7, 8'h18);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule